// File: doc/BRIEF.md
# Data Trace Packet Compressor

This block takes retired load and store events from a hart and turns each one into a compact data trace packet. An event carries its direction (load or store), an access size code, a byte address and a data value. The block keeps a separate compression history for each access size. After reset, or after an instruction trace synchronisation, the first access of a given size is reported in full. Later accesses of that size carry the address as a difference from the previous address of that size. Their data is carried either raw or XOR-encoded against the previous data of that size, whichever needs fewer bytes.

Upper data bytes that only repeat the sign bit are dropped, and a length field says how many bytes remain. Address bits made redundant by alignment are removed. Two run-time controls can leave the address or the data out of every packet; the packets carry no marker of this choice. Each packet leaves on a valid/ready port as a zero-padded bit vector, with a count of the bits that are used. The event input is stalled while a packet waits at the output.

Top module: `dtrace_compressor`

## Requirements
- R1: After reset `pkt_valid_o` is low, `ev_ready_o` is high and no size has history, so the first packet of every size carries diff code 00.
- R2: Packet fields are packed from bit 0 upward in this order: format (2 bits), size (2 bits at the default width), diff (2 bits), then, when data is included, data_len (2 bits) followed by data_len+1 data bytes, then, when the address is included, the address field (ADDR_W bits). `pkt_len_o` equals the number of bits used, and all bits above it are zero.
- R3: Format bit 0 is 1 for a store and 0 for a load. The address value to be sent is either the full address or the difference. If its low `size` bits are zero, it is sent shifted right by `size` and format bit 1 is 0. Otherwise it is sent unshifted and format bit 1 is 1. Format bit 1 is 0 when the address is omitted.
- R4: The first accepted event of a size after reset or sync uses diff code 00, the full byte address and the raw data value.
- R5: A later event of the same size sends its address as the current address minus the previous address of that size, modulo 2^ADDR_W. Events of other sizes do not change this history.
- R6: For a non-first event with data included, diff code 10 (XOR against the previous data of that size) is used when the XOR value needs strictly fewer bytes than the raw value. Otherwise diff code 01 (raw) is used.
- R7: The data value is first sign-extended from the access width of 2^size bytes. The value sent, raw or XOR, is cut to the fewest bytes, at least one, from which sign extension restores it, and data_len equals that byte count minus one.
- R8: With `cfg_no_data_i` high, data_len and data are left out and non-first events use diff code 01. With `cfg_no_addr_i` high, the address field is left out. History is updated in both cases.
- R9: `sync_i` clears the history of every size. An event accepted in the same cycle is encoded as a first event.
- R10: While `pkt_valid_o` is high and `pkt_ready_i` is low, the packet and its length stay unchanged and `ev_ready_o` is low. An accepted event appears at the output on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Instruction trace sync; clears compression history |
| cfg_no_addr_i | input | 1 | Omit the address field from packets |
| cfg_no_data_i | input | 1 | Omit the data length and data fields from packets |
| ev_valid_i | input | 1 | Event present |
| ev_ready_o | output | 1 | Event accepted when high together with valid |
| ev_store_i | input | 1 | 1 = store, 0 = load |
| ev_size_i | input | SZ_W (2) | Access is 2^size bytes |
| ev_addr_i | input | ADDR_W (32) | Byte address |
| ev_data_i | input | DATA_W (32) | Data value, low 2^size bytes significant |
| pkt_valid_o | output | 1 | Packet present |
| pkt_ready_i | input | 1 | Downstream takes the packet |
| pkt_bits_o | output | PKT_W (72) | Packet bits, LSB first, zero above length |
| pkt_len_o | output | LEN_W (7) | Number of used packet bits |

## Verification
Directed events first separate the full, raw and XOR encodings, using data pairs that differ only in low bits and a byte load of 0xFF that truncates to a single byte. Aligned and unaligned address steps show whether the shift and format bit 1 follow the value that is actually sent. A long mixed sweep over all four address/data omission settings interleaves the three sizes, with periodic syncs. Its address steps are small, aligned, unaligned, repeated and random, and its data values are small signed, near-previous, sign-heavy and random. This shows whether history stays separate per size and whether the raw/XOR choice and byte truncation are right at each length. A back-pressure sequence holds an event at the stalled input, so that a stalled packet and a pipelined handover can be told apart.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int FMT_W  = 2;
  localparam int DIFF_W = 2;

  typedef enum logic [DIFF_W-1:0] {
    DIFF_FULL = 2'b00,
    DIFF_RAW  = 2'b01,
    DIFF_XOR  = 2'b10
  } diff_e;
endpackage

// File: rtl/dtc_history.sv
module dtc_history #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NSZ    = 3,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [SZ_W-1:0]   wr_size_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SZ_W-1:0]   rd_size_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NSZ-1:0]    vld_w;
  logic [ADDR_W-1:0] addr_w [NSZ];
  logic [DATA_W-1:0] data_w [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_slot
    logic              vld_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] data_r;
    logic              sel;

    assign sel = wr_i && (wr_size_i == SZ_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_r  <= 1'b0;
        addr_r <= '0;
        data_r <= '0;
      end else if (sel) begin
        vld_r  <= 1'b1;
        addr_r <= wr_addr_i;
        data_r <= wr_data_i;
      end else if (clear_i) begin
        vld_r  <= 1'b0;
      end
    end

    assign vld_w[g]  = vld_r;
    assign addr_w[g] = addr_r;
    assign data_w[g] = data_r;
  end

  always_comb begin
    rd_valid_o = 1'b0;
    rd_addr_o  = '0;
    rd_data_o  = '0;
    for (int i = 0; i < NSZ; i++) begin
      if (rd_size_i == SZ_W'(i)) begin
        rd_valid_o = vld_w[i];
        rd_addr_o  = addr_w[i];
        rd_data_o  = data_w[i];
      end
    end
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !wr_i) |=> (vld_w == '0)); // R9

  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (int'(wr_size_i) < NSZ)) |=> ((vld_w >> $past(wr_size_i)) & NSZ'(1)) != '0); // R5
endmodule

// File: rtl/dtc_encoder.sv
module dtc_encoder
  import dtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NB     = 4,
  parameter int NSZ    = 3,
  parameter int SZ_W   = 2,
  parameter int DL_W   = 2
) (
  input  logic              store_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sync_i,
  input  logic              no_addr_i,
  input  logic              no_data_i,
  input  logic              h_valid_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [DATA_W-1:0] h_data_i,
  output logic [FMT_W-1:0]  fmt_o,
  output diff_e             diff_o,
  output logic              has_data_o,
  output logic              has_addr_o,
  output logic [DL_W-1:0]   dlen_o,
  output logic [DATA_W-1:0] dval_o,
  output logic [ADDR_W-1:0] afield_o,
  output logic [DATA_W-1:0] ext_o,
  output logic              first_o
);
  // fewest bytes (>=1) whose sign extension restores v
  function automatic int f_bytes(input logic [DATA_W-1:0] v);
    int n;
    logic [DATA_W-1:0] t;
    n = NB;
    for (int k = NB - 1; k >= 1; k--) begin
      t = DATA_W'($signed(v) >>> (8 * k - 1));
      if (t == '0 || t == '1) n = k;
    end
    return n;
  endfunction

  // sign extension from an access of 2^sz bytes
  function automatic logic [DATA_W-1:0] f_sext(input logic [DATA_W-1:0] d,
                                               input logic [SZ_W-1:0] sz);
    logic [DATA_W-1:0] r;
    logic sgn;
    int nbytes;
    nbytes = 1 << sz;
    if (nbytes > NB) nbytes = NB;
    sgn = d[8 * nbytes - 1];
    for (int b = 0; b < NB; b++)
      r[8*b +: 8] = (b < nbytes) ? d[8*b +: 8] : {8{sgn}};
    return r;
  endfunction

  logic [DATA_W-1:0] xor_val;
  int                nb_raw, nb_xor, nb_sel;
  logic              use_xor;
  logic [ADDR_W-1:0] addr_val, low_mask;
  logic              aligned;

  assign first_o    = sync_i || !h_valid_i;
  assign has_data_o = !no_data_i;
  assign has_addr_o = !no_addr_i;
  assign ext_o      = f_sext(data_i, size_i);
  assign xor_val    = ext_o ^ h_data_i;
  assign nb_raw     = f_bytes(ext_o);
  assign nb_xor     = f_bytes(xor_val);
  assign use_xor    = !first_o && has_data_o && (nb_xor < nb_raw);
  assign nb_sel     = use_xor ? nb_xor : nb_raw;
  assign dval_o     = use_xor ? xor_val : ext_o;
  assign dlen_o     = DL_W'(nb_sel - 1);

  always_comb begin
    if (first_o)      diff_o = DIFF_FULL;
    else if (use_xor) diff_o = DIFF_XOR;
    else              diff_o = DIFF_RAW;
  end

  assign addr_val = first_o ? addr_i : (addr_i - h_addr_i);
  assign low_mask = (ADDR_W'(1) << size_i) - ADDR_W'(1);
  assign aligned  = (addr_val & low_mask) == '0;
  assign afield_o = aligned ? (addr_val >> size_i) : addr_val;
  assign fmt_o    = {(!aligned && has_addr_o), store_i};
endmodule

// File: rtl/dtc_packer.sv
module dtc_packer
  import dtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NB     = 4,
  parameter int SZ_W   = 2,
  parameter int DL_W   = 2,
  parameter int PKT_W  = 72,
  parameter int LEN_W  = 7
) (
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [SZ_W-1:0]   size_i,
  input  diff_e             diff_i,
  input  logic              has_data_i,
  input  logic [DL_W-1:0]   dlen_i,
  input  logic [DATA_W-1:0] dval_i,
  input  logic              has_addr_i,
  input  logic [ADDR_W-1:0] afield_i,
  output logic [PKT_W-1:0]  bits_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int HDR_W = FMT_W + SZ_W + DIFF_W;

  logic [DATA_W-1:0] dmask;

  always_comb begin
    for (int b = 0; b < NB; b++)
      dmask[8*b +: 8] = (b <= int'(dlen_i)) ? dval_i[8*b +: 8] : 8'h00;
  end

  always_comb begin
    int pos;
    bits_o = PKT_W'(fmt_i)
           | (PKT_W'(size_i) << FMT_W)
           | (PKT_W'(diff_i) << (FMT_W + SZ_W));
    pos = HDR_W;
    if (has_data_i) begin
      bits_o = bits_o | (PKT_W'(dlen_i) << pos);
      pos    = pos + DL_W;
      bits_o = bits_o | (PKT_W'(dmask) << pos);
      pos    = pos + 8 * (int'(dlen_i) + 1);
    end
    if (has_addr_i) begin
      bits_o = bits_o | (PKT_W'(afield_i) << pos);
      pos    = pos + ADDR_W;
    end
    len_o = LEN_W'(pos);
  end
endmodule

// File: rtl/dtrace_compressor.sv
module dtrace_compressor
  import dtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int NSZ   = $clog2(NB) + 1,
  localparam int SZ_W  = ($clog2($clog2(NB + 1)) > 1) ? $clog2($clog2(NB + 1)) : 1,
  localparam int DL_W  = (NB > 1) ? $clog2(NB) : 1,
  localparam int HDR_W = FMT_W + SZ_W + DIFF_W,
  localparam int PKT_W = HDR_W + DL_W + DATA_W + ADDR_W,
  localparam int LEN_W = $clog2(PKT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              cfg_no_addr_i,
  input  logic              cfg_no_data_i,
  input  logic              ev_valid_i,
  output logic              ev_ready_o,
  input  logic              ev_store_i,
  input  logic [SZ_W-1:0]   ev_size_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic [DATA_W-1:0] ev_data_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [PKT_W-1:0]  pkt_bits_o,
  output logic [LEN_W-1:0]  pkt_len_o
);
  logic              accept;
  logic              h_valid;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;
  logic [FMT_W-1:0]  enc_fmt;
  diff_e             enc_diff;
  logic              enc_has_data, enc_has_addr, enc_first;
  logic [DL_W-1:0]   enc_dlen;
  logic [DATA_W-1:0] enc_dval, enc_ext;
  logic [ADDR_W-1:0] enc_afield;
  logic [PKT_W-1:0]  pk_bits;
  logic [LEN_W-1:0]  pk_len;
  logic [DATA_W-1:0] restore_chk;

  assign ev_ready_o = !pkt_valid_o || pkt_ready_i;
  assign accept     = ev_valid_i && ev_ready_o;

  dtc_history #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSZ(NSZ), .SZ_W(SZ_W)) hist_i (
    .clk(clk), .rst_n(rst_n), .clear_i(sync_i),
    .wr_i(accept), .wr_size_i(ev_size_i), .wr_addr_i(ev_addr_i), .wr_data_i(enc_ext),
    .rd_size_i(ev_size_i), .rd_valid_o(h_valid), .rd_addr_o(h_addr), .rd_data_o(h_data)
  );

  dtc_encoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB), .NSZ(NSZ),
                .SZ_W(SZ_W), .DL_W(DL_W)) enc_i (
    .store_i(ev_store_i), .size_i(ev_size_i), .addr_i(ev_addr_i), .data_i(ev_data_i),
    .sync_i(sync_i), .no_addr_i(cfg_no_addr_i), .no_data_i(cfg_no_data_i),
    .h_valid_i(h_valid), .h_addr_i(h_addr), .h_data_i(h_data),
    .fmt_o(enc_fmt), .diff_o(enc_diff), .has_data_o(enc_has_data), .has_addr_o(enc_has_addr),
    .dlen_o(enc_dlen), .dval_o(enc_dval), .afield_o(enc_afield), .ext_o(enc_ext),
    .first_o(enc_first)
  );

  dtc_packer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB), .SZ_W(SZ_W), .DL_W(DL_W),
               .PKT_W(PKT_W), .LEN_W(LEN_W)) pack_i (
    .fmt_i(enc_fmt), .size_i(ev_size_i), .diff_i(enc_diff), .has_data_i(enc_has_data),
    .dlen_i(enc_dlen), .dval_i(enc_dval), .has_addr_i(enc_has_addr), .afield_i(enc_afield),
    .bits_o(pk_bits), .len_o(pk_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_valid_o <= 1'b0;
      pkt_bits_o  <= '0;
      pkt_len_o   <= '0;
    end else if (accept) begin
      pkt_valid_o <= 1'b1;
      pkt_bits_o  <= pk_bits;
      pkt_len_o   <= pk_len;
    end else if (pkt_ready_i) begin
      pkt_valid_o <= 1'b0;
    end
  end

  // sign extension from the kept bytes, computed independently of the byte counter
  always_comb begin
    int sh;
    sh = DATA_W - 8 * (int'(enc_dlen) + 1);
    restore_chk = DATA_W'($signed(enc_dval << sh) >>> sh);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i) |=>
      (pkt_valid_o && $stable(pkt_bits_o) && $stable(pkt_len_o))); // R10

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i) |-> !ev_ready_o); // R10

  AST_SYNC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sync_i) |=> (pkt_bits_o[FMT_W+SZ_W +: DIFF_W] == 2'b00)); // R9

  AST_TRUNC_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && enc_has_data) |-> (restore_chk == enc_dval)); // R7

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (int'(pkt_len_o) >= HDR_W && int'(pkt_len_o) <= PKT_W)); // R2

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i |-> (int'(ev_size_i) < NSZ)); // R3
endmodule

// File: tb/dtrace_compressor_tb_top.sv
module dtrace_compressor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, cfg_no_addr_i = 1'b0, cfg_no_data_i = 1'b0;
  logic ev_valid_i = 1'b0, ev_store_i = 1'b0;
  logic [1:0]  ev_size_i = '0;
  logic [31:0] ev_addr_i = '0, ev_data_i = '0;
  logic ev_ready_o, pkt_valid_o;
  logic pkt_ready_i = 1'b1;
  logic [PW-1:0] pkt_bits_o;
  logic [6:0] pkt_len_o;

  dtrace_compressor dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .cfg_no_addr_i(cfg_no_addr_i), .cfg_no_data_i(cfg_no_data_i),
    .ev_valid_i(ev_valid_i), .ev_ready_o(ev_ready_o), .ev_store_i(ev_store_i),
    .ev_size_i(ev_size_i), .ev_addr_i(ev_addr_i), .ev_data_i(ev_data_i),
    .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i),
    .pkt_bits_o(pkt_bits_o), .pkt_len_o(pkt_len_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  bit          pv [3];
  logic [31:0] pa [3];
  logic [31:0] pd [3];
  logic [PW-1:0] e_bits;
  int            e_len;
  logic [31:0] rs = 32'h1234_5678;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_sext(input logic [31:0] d, input int sz);
    int sh;
    sh = 32 - (8 << sz);
    return $unsigned($signed(d << sh) >>> sh);
  endfunction

  function automatic int m_nb(input logic [31:0] v);
    for (int n = 1; n <= 4; n++) begin
      int sh;
      sh = 32 - 8 * n;
      if ($unsigned($signed(v << sh) >>> sh) == v) return n;
    end
    return 4;
  endfunction

  task automatic rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
  endtask

  // expected packet, then model history update
  task automatic model(input bit st, input int sz, input logic [31:0] a, input logic [31:0] d,
                       input bit sy);
    bit first, usex, al;
    logic [31:0] ext, x, dv, av, af;
    logic [63:0] msk;
    int nr, nx, n, p, diff;
    first = sy || !pv[sz];
    ext = m_sext(d, sz);
    x = ext ^ pd[sz];
    nr = m_nb(ext);
    nx = m_nb(x);
    usex = !first && !cfg_no_data_i && (nx < nr);
    diff = first ? 0 : (usex ? 2 : 1);
    dv = usex ? x : ext;
    n = usex ? nx : nr;
    av = first ? a : a - pa[sz];
    al = (av % (32'd1 << sz)) == 0;
    af = al ? av / (32'd1 << sz) : av;
    e_bits = PW'(st) + PW'((al || cfg_no_addr_i) ? 0 : 2) + PW'(sz * 4) + PW'(diff * 16);
    p = 6;
    if (!cfg_no_data_i) begin
      e_bits = e_bits | (PW'(n - 1) << p);
      p += 2;
      msk = (64'd1 << (8 * n)) - 64'd1;
      e_bits = e_bits | (PW'(dv & msk[31:0]) << p);
      p += 8 * n;
    end
    if (!cfg_no_addr_i) begin
      e_bits = e_bits | (PW'(af) << p);
      p += 32;
    end
    e_len = p;
    if (sy) for (int i = 0; i < 3; i++) pv[i] = 0;
    pv[sz] = 1;
    pa[sz] = a;
    pd[sz] = ext;
  endtask

  task automatic send(input string tag, input bit st, input int sz, input logic [31:0] a,
                      input logic [31:0] d, input bit sy);
    @(negedge clk);
    ev_valid_i = 1; ev_store_i = st; ev_size_i = 2'(sz); ev_addr_i = a; ev_data_i = d;
    sync_i = sy;
    model(st, sz, a, d, sy);
    @(posedge clk);
    @(negedge clk);
    ev_valid_i = 0; sync_i = 0;
    chk({tag, " valid"}, 128'(pkt_valid_o), 128'd1);
    chk({tag, " bits"}, 128'(pkt_bits_o), 128'(e_bits));
    chk({tag, " len"}, 128'(pkt_len_o), 128'(e_len));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [PW-1:0] hold_bits;
    logic [PW-1:0] exp_b;
    int exp_l;
    for (int i = 0; i < 3; i++) begin pv[i] = 0; pa[i] = 0; pd[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset valid", 128'(pkt_valid_o), 128'd0);
    chk("R1 reset ready", 128'(ev_ready_o), 128'd1);

    // directed
    send("R1 R4 first word", 0, 2, 32'h1000, 32'h1234_5678, 0);
    chk("R4 diff full", 128'(pkt_bits_o[5:4]), 128'd0);
    send("R5 R6 xor pick", 1, 2, 32'h1008, 32'h1234_5679, 0);
    chk("R6 diff xor", 128'(pkt_bits_o[5:4]), 128'd2);
    chk("R5 R2 addr delta", 128'(pkt_bits_o[47:16]), 128'd2);
    send("R7 byte FF first", 0, 0, 32'h2003, 32'h0000_00FF, 0);
    chk("R7 one byte len", 128'(pkt_len_o), 128'd48);
    send("R3 unaligned delta", 0, 2, 32'h1009, 32'h0000_0010, 0);
    chk("R3 fmt unaligned", 128'(pkt_bits_o[1]), 128'd1);
    send("R6 raw tie", 0, 2, 32'h100D, 32'h0000_0020, 0);
    chk("R6 diff raw", 128'(pkt_bits_o[5:4]), 128'd1);
    send("R5 other size", 1, 1, 32'h3000, 32'hFFFF_8001, 0);
    send("R5 size2 intact", 0, 2, 32'h1011, 32'h0000_0020, 0);
    send("R9 sync same cycle", 0, 2, 32'h1015, 32'h0000_0021, 1);
    chk("R9 diff full", 128'(pkt_bits_o[5:4]), 128'd0);
    send("R9 size1 cleared", 0, 1, 32'h3002, 32'h0000_0001, 0);

    // back-pressure
    @(negedge clk);
    pkt_ready_i = 0;
    ev_valid_i = 1; ev_store_i = 1; ev_size_i = 2'd1; ev_addr_i = 32'h3006; ev_data_i = 32'h0000_0102;
    model(1, 1, 32'h3006, 32'h0000_0102, 0);
    exp_b = e_bits; exp_l = e_len;
    @(posedge clk);
    @(negedge clk);
    chk("R10 stall valid", 128'(pkt_valid_o), 128'd1);
    chk("R10 stall ready low", 128'(ev_ready_o), 128'd0);
    chk("R10 stall bits", 128'(pkt_bits_o), 128'(exp_b));
    hold_bits = pkt_bits_o;
    ev_store_i = 0; ev_addr_i = 32'h3008; ev_data_i = 32'h0000_0103;
    model(0, 1, 32'h3008, 32'h0000_0103, 0);
    repeat (2) begin
      @(negedge clk);
      chk("R10 hold bits", 128'(pkt_bits_o), 128'(hold_bits));
      chk("R10 hold len", 128'(pkt_len_o), 128'(exp_l));
      chk("R10 hold ready low", 128'(ev_ready_o), 128'd0);
    end
    pkt_ready_i = 1;
    @(posedge clk);
    @(negedge clk);
    ev_valid_i = 0;
    chk("R10 handover bits", 128'(pkt_bits_o), 128'(e_bits));
    chk("R10 handover len", 128'(pkt_len_o), 128'(e_len));
    @(negedge clk);
    chk("R10 drained", 128'(pkt_valid_o), 128'd0);

    // omission modes, directed
    cfg_no_data_i = 1;
    send("R8 no data", 0, 2, 32'h4000, 32'h7777_7777, 0);
    chk("R8 no data len", 128'(pkt_len_o), 128'd38);
    cfg_no_data_i = 0; cfg_no_addr_i = 1;
    send("R8 no addr", 0, 0, 32'h4001, 32'h0000_0005, 0);
    chk("R8 no addr len", 128'(pkt_len_o), 128'd16);
    cfg_no_addr_i = 0;

    // sweep over all omission settings
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      cfg_no_addr_i = m[0];
      cfg_no_data_i = m[1];
      for (int e = 0; e < 150; e++) begin
        int sz, ka, kd;
        logic [31:0] a, d;
        bit sy;
        rnd(); sz = int'(rs % 3);
        rnd(); ka = int'(rs % 4);
        rnd(); kd = int'(rs % 4);
        rnd();
        case (ka)
          0: a = pa[sz] + ((rs % 8) << sz);
          1: a = rs;
          2: a = pa[sz] - (rs % 5);
          default: a = pa[sz];
        endcase
        rnd();
        case (kd)
          0: d = (rs % 256) - 128;
          1: d = pd[sz] ^ (rs & 32'h0000_001F);
          2: d = rs;
          default: d = 32'hFFFF_FF00 | (rs & 32'hFF);
        endcase
        sy = (e % 37) == 36;
        send("R2 R3 R5 R6 R7 R8 R9 sweep", rs[0], sz, a, d, sy);
      end
    end
    finish_run();
  end
endmodule